// File: doc/BRIEF.md
# Write-Only Configuration Register Slave on I2C

This block is an I2C target that can only be written. It holds six byte-wide configuration registers whose bits drive clock-enable and clock-select controls elsewhere on the chip. SCL and SDA are sampled on a faster system clock, cleaned up, and decoded into START, STOP and clock edges.

A transaction begins with the write address byte 0xD2, which is the 7-bit address 0x69 followed by a write bit of 0. Two header bytes come next: a command byte and a count byte. Both are acknowledged and both are discarded. Every data byte after them lands in the next register, and each transaction starts again at register 0.

A power-down input, active low, releases the bus pins and freezes the registers. A power-on reset is the only thing that restores the defaults.

Top module: `cfg_i2c_wr_slave`

## Requirements
- R1: An address byte of 0xD2 is acknowledged: the block pulls SDA low while SCL is high during the ninth clock of that byte.
- R2: An address byte other than 0xD2 is not acknowledged. This includes 0xD3, the read request. After such a byte, every further byte is ignored and left unacknowledged until the next START, and the registers do not change.
- R3: The two bytes after an accepted address are the command byte and the count byte. Each is acknowledged whatever its value, and neither value changes any register.
- R4: Data bytes are written to registers 0, 1, 2, 3, 4, 5 in that order, and each is acknowledged. A new START, including a repeated START, restarts the sequence at register 0. Register k occupies bits [8k+7:8k] of cfg_o.
- R5: After a STOP, every data byte received in full before it stays written. A byte cut short by a STOP or a repeated START is discarded.
- R6: A data byte beyond register 5 is not acknowledged and changes no register.
- R7: While pd_ni is low, pins_hiz_o is 1 and sda_pull_o is 0. The bus is ignored, so a complete write draws no acknowledge and the registers hold their contents.
- R8: Taking pd_ni high again leaves every register unchanged. The next transaction then works normally.
- R9: After reset, register 0 holds the parameter REG0_INIT and registers 1 to 5 hold 0xFF. sda_pull_o and pins_hiz_o are both 0.
- R10: The block never returns data. sda_pull_o changes only while the filtered SCL is low, and it is asserted only in an acknowledge slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than SCL |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| pd_ni | input | 1 | Active-low power-down |
| scl_i | input | 1 | SCL pin level |
| sda_i | input | 1 | SDA pin level |
| sda_pull_o | output | 1 | 1 pulls SDA low (open-drain acknowledge) |
| pins_hiz_o | output | 1 | 1 places the SDA and SCL pads in high impedance |
| cfg_o | output | 48 | Register contents, register k at bits [8k+7:8k] |

## Verification
The checker watches four things on every cycle: the SDA pull and the pin release are never active together, the registers are frozen whenever power-down is asserted, a write never targets an index past the last register, and the pull changes only while SCL is low. Other behaviour depends on a whole byte stream and is shown only by the bench scenarios. This covers which address values are acknowledged, that the header bytes are discarded, that the registers fill in order from 0 and restart at a repeated START, that a truncated byte is dropped, that an overflow byte is refused, and the reset defaults.

// File: rtl/cfg_i2c_pkg.sv
package cfg_i2c_pkg;
  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned HDR_BYTES = 3;  // address, command, count

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_SKIP
  } i2c_st_e;
endpackage

// File: rtl/i2c_pin_filter.sv
module i2c_pin_filter #(
  parameter int unsigned NLINE = 2,
  parameter int unsigned FILT  = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NLINE-1:0] raw_i,
  output logic [NLINE-1:0] flt_o
);
  for (genvar g = 0; g < NLINE; g++) begin : g_line
    logic [1:0]      sync_q;
    logic [FILT-1:0] hist_q;
    logic            out_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        sync_q <= '1;
        hist_q <= '1;
        out_q  <= 1'b1;
      end else begin
        sync_q <= {sync_q[0], raw_i[g]};
        hist_q <= {hist_q[FILT-2:0], sync_q[1]};
        // follow only after FILT equal samples
        if (&hist_q)       out_q <= 1'b1;
        else if (~|hist_q) out_q <= 1'b0;
      end
    end

    assign flt_o[g] = out_q;
  end
endmodule

// File: rtl/i2c_bus_events.sv
module i2c_bus_events (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic start_o,
  output logic stop_o,
  output logic scl_rise_o,
  output logic scl_fall_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign start_o    = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_o     = scl_i & scl_q & ~sda_q & sda_i;
  assign scl_rise_o = scl_i & ~scl_q;
  assign scl_fall_o = ~scl_i & scl_q;
endmodule

// File: rtl/i2c_wr_fsm.sv
module i2c_wr_fsm
  import cfg_i2c_pkg::*;
#(
  parameter int unsigned NREG  = 6,
  parameter logic [6:0]  ADDR7 = 7'h69,
  localparam int unsigned IDX_W = $clog2(NREG),
  localparam int unsigned CNT_W = $clog2(HDR_BYTES + NREG + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              sda_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  output logic              sda_pull_o,
  output logic              wr_en_o,
  output logic [IDX_W-1:0]  wr_idx_o,
  output logic [BYTE_W-1:0] wr_data_o
);
  i2c_st_e           st_q;
  logic [2:0]        bit_q;
  logic              full_q;
  logic              ack_hi_q;
  logic [BYTE_W-1:0] sh_q;
  logic [CNT_W-1:0]  idx_q;
  logic              pull_q;

  logic             addr_ok, in_reg, take;
  logic [CNT_W-1:0] reg_off;

  always_comb begin
    addr_ok = (sh_q == {ADDR7, 1'b0});
    in_reg  = (idx_q >= CNT_W'(HDR_BYTES)) && (idx_q < CNT_W'(HDR_BYTES + NREG));
    take    = (idx_q == '0) ? addr_ok : (idx_q < CNT_W'(HDR_BYTES + NREG));
    reg_off = idx_q - CNT_W'(HDR_BYTES);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      bit_q     <= '0;
      full_q    <= 1'b0;
      ack_hi_q  <= 1'b0;
      sh_q      <= '0;
      idx_q     <= '0;
      pull_q    <= 1'b0;
      wr_en_o   <= 1'b0;
      wr_idx_o  <= '0;
      wr_data_o <= '0;
    end else begin
      wr_en_o <= 1'b0;
      if (!en_i) begin
        st_q   <= ST_IDLE;
        pull_q <= 1'b0;
        full_q <= 1'b0;
      end else if (start_i) begin
        st_q   <= ST_RX;
        bit_q  <= '0;
        full_q <= 1'b0;
        idx_q  <= '0;
        pull_q <= 1'b0;
      end else if (stop_i) begin
        st_q   <= ST_IDLE;
        pull_q <= 1'b0;
        full_q <= 1'b0;
      end else begin
        unique case (st_q)
          ST_RX: begin
            if (scl_rise_i && !full_q) begin
              sh_q  <= {sh_q[BYTE_W-2:0], sda_i};
              bit_q <= bit_q + 3'd1;
              if (bit_q == 3'd7) full_q <= 1'b1;
            end else if (scl_fall_i && full_q) begin
              full_q <= 1'b0;
              if (take) begin
                st_q     <= ST_ACK;
                pull_q   <= 1'b1;
                ack_hi_q <= 1'b0;
                if (in_reg) begin
                  wr_en_o   <= 1'b1;
                  wr_idx_o  <= reg_off[IDX_W-1:0];
                  wr_data_o <= sh_q;
                end
              end else begin
                st_q <= ST_SKIP;
              end
            end
          end
          ST_ACK: begin
            if (scl_rise_i) begin
              ack_hi_q <= 1'b1;
            end else if (scl_fall_i && ack_hi_q) begin
              pull_q   <= 1'b0;
              ack_hi_q <= 1'b0;
              st_q     <= ST_RX;
              bit_q    <= '0;
              idx_q    <= idx_q + CNT_W'(1);
            end
          end
          default: ;  // idle / skip wait for START
        endcase
      end
    end
  end

  assign sda_pull_o = pull_q;
endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank
  import cfg_i2c_pkg::*;
#(
  parameter int unsigned       NREG      = 6,
  parameter logic [BYTE_W-1:0] REG0_INIT = 8'h3C,
  localparam int unsigned IDX_W = $clog2(NREG)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   wr_en_i,
  input  logic [IDX_W-1:0]       wr_idx_i,
  input  logic [BYTE_W-1:0]      wr_data_i,
  output logic [NREG*BYTE_W-1:0] cfg_o
);
  for (genvar g = 0; g < NREG; g++) begin : g_reg
    localparam logic [BYTE_W-1:0] INIT = (g == 0) ? REG0_INIT : '1;
    logic [BYTE_W-1:0] r_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                    r_q <= INIT;
      else if (wr_en_i && wr_idx_i == IDX_W'(g))      r_q <= wr_data_i;
    end

    assign cfg_o[g*BYTE_W +: BYTE_W] = r_q;
  end
endmodule

// File: rtl/cfg_i2c_wr_slave.sv
module cfg_i2c_wr_slave
  import cfg_i2c_pkg::*;
#(
  parameter int unsigned       NREG      = 6,
  parameter logic [6:0]        ADDR7     = 7'h69,
  parameter logic [BYTE_W-1:0] REG0_INIT = 8'h3C,
  parameter int unsigned       FILT      = 3,
  localparam int unsigned IDX_W = $clog2(NREG)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   pd_ni,
  input  logic                   scl_i,
  input  logic                   sda_i,
  output logic                   sda_pull_o,
  output logic                   pins_hiz_o,
  output logic [NREG*BYTE_W-1:0] cfg_o
);
  logic [1:0]        flt;
  logic              scl_f, sda_f;
  logic              start, stop, scl_rise, scl_fall;
  logic              fsm_pull, wr_en;
  logic [IDX_W-1:0]  wr_idx;
  logic [BYTE_W-1:0] wr_data;

  i2c_pin_filter #(.NLINE(2), .FILT(FILT)) u_filt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .raw_i ({scl_i, sda_i}),
    .flt_o (flt)
  );
  assign scl_f = flt[1];
  assign sda_f = flt[0];

  i2c_bus_events u_evt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .scl_i     (scl_f),
    .sda_i     (sda_f),
    .start_o   (start),
    .stop_o    (stop),
    .scl_rise_o(scl_rise),
    .scl_fall_o(scl_fall)
  );

  i2c_wr_fsm #(.NREG(NREG), .ADDR7(ADDR7)) u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (pd_ni),
    .sda_i     (sda_f),
    .start_i   (start),
    .stop_i    (stop),
    .scl_rise_i(scl_rise),
    .scl_fall_i(scl_fall),
    .sda_pull_o(fsm_pull),
    .wr_en_o   (wr_en),
    .wr_idx_o  (wr_idx),
    .wr_data_o (wr_data)
  );

  cfg_reg_bank #(.NREG(NREG), .REG0_INIT(REG0_INIT)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en & pd_ni),
    .wr_idx_i (wr_idx),
    .wr_data_i(wr_data),
    .cfg_o    (cfg_o)
  );

  assign sda_pull_o = fsm_pull & pd_ni;
  assign pins_hiz_o = ~pd_ni;
endmodule

// File: rtl/cfg_i2c_wr_chk.sv
module cfg_i2c_wr_chk #(
  parameter int unsigned NREG = 6,
  parameter int unsigned DW   = 8,
  localparam int unsigned IDX_W = $clog2(NREG)
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               pd_ni,
  input logic               sda_pull_o,
  input logic               pins_hiz_o,
  input logic [NREG*DW-1:0] cfg_o,
  input logic               scl_f,
  input logic               wr_en,
  input logic [IDX_W-1:0]   wr_idx
);
  // R7
  pull_vs_hiz_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pins_hiz_o |-> !sda_pull_o);

  // R7
  pd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pd_ni |=> $stable(cfg_o));

  // R6
  wr_idx_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en |-> (wr_idx < IDX_W'(NREG)));

  // R10
  pull_scl_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pd_ni && $past(pd_ni) && (sda_pull_o != $past(sda_pull_o))) |-> !scl_f);
endmodule

bind cfg_i2c_wr_slave cfg_i2c_wr_chk #(.NREG(NREG), .DW(cfg_i2c_pkg::BYTE_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .pd_ni     (pd_ni),
  .sda_pull_o(sda_pull_o),
  .pins_hiz_o(pins_hiz_o),
  .cfg_o     (cfg_o),
  .scl_f     (scl_f),
  .wr_en     (wr_en),
  .wr_idx    (wr_idx)
);

// File: tb/sim_cfg_i2c_wr_slave.sv
module sim_cfg_i2c_wr_slave;
  localparam int HQ = 8;  // quarter SCL period in clk cycles
  localparam logic [7:0] R0_DEF = 8'hC5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pd_n = 1'b1;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_pull, pins_hiz;
  logic [47:0] cfg;
  logic sda_line;

  int checks = 0;
  int errors = 0;
  bit ack_q[$];
  event ack_ev;

  always #2 clk = ~clk;  // 250 MHz

  assign sda_line = sda_m & ~sda_pull;

  cfg_i2c_wr_slave #(.REG0_INIT(R0_DEF)) u0 (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .pd_ni     (pd_n),
    .scl_i     (scl_m),
    .sda_i     (sda_line),
    .sda_pull_o(sda_pull),
    .pins_hiz_o(pins_hiz),
    .cfg_o     (cfg)
  );

  task automatic chk(input bit ok, input string req, input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // scoreboard monitor: pops the expected acknowledge for each ninth clock
  initial begin
    forever begin
      @(ack_ev);
      if (ack_q.size() == 0) begin
        chk(1'b0, "R10 unexpected ack slot", 48'(sda_line), 48'd1);
      end else begin
        automatic bit exp = ack_q.pop_front();
        chk((!sda_line) == exp, "R1/R2/R3/R4/R6 ack", 48'(!sda_line), 48'(exp));
      end
    end
  end

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic i2c_start;
    sda_m = 1'b1; wq(HQ);
    scl_m = 1'b1; wq(HQ);
    sda_m = 1'b0; wq(2*HQ);
    scl_m = 1'b0; wq(HQ);
  endtask

  task automatic i2c_stop;
    sda_m = 1'b0; wq(HQ);
    scl_m = 1'b1; wq(2*HQ);
    sda_m = 1'b1; wq(2*HQ);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; wq(HQ);
      scl_m = 1'b1; wq(2*HQ);
      scl_m = 1'b0; wq(HQ);
    end
  endtask

  // driver: pushes the expected acknowledge, then clocks the ninth bit
  task automatic send_byte(input logic [7:0] b, input bit exp_ack);
    send_bits(b, 8);
    sda_m = 1'b1; wq(HQ);
    scl_m = 1'b1; wq(HQ);
    ack_q.push_back(exp_ack);
    ->ack_ev;
    wq(HQ);
    scl_m = 1'b0; wq(HQ);
  endtask

  task automatic chk_regs(input logic [47:0] exp, input string req);
    for (int k = 0; k < 6; k++)
      chk(cfg[k*8 +: 8] == exp[k*8 +: 8], req, 48'(cfg[k*8 +: 8]), 48'(exp[k*8 +: 8]));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", 48'd0, 48'd1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [47:0] exp;
    wq(5);
    rst_n = 1'b1;
    wq(10);
    // R9 reset state
    exp = {8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, R0_DEF};
    chk_regs(exp, "R9 reset value");
    chk(!sda_pull && !pins_hiz, "R9 bus outputs", 48'({sda_pull, pins_hiz}), 48'd0);

    // R1 R3 R4 R5: three data bytes, then STOP
    i2c_start;
    send_byte(8'hD2, 1);   // R1
    send_byte(8'h04, 1);   // R3 command ignored
    send_byte(8'h02, 1);   // R3 count ignored
    send_byte(8'h11, 1);
    send_byte(8'h22, 1);
    send_byte(8'h33, 1);
    i2c_stop;
    exp = {8'hFF, 8'hFF, 8'hFF, 8'h33, 8'h22, 8'h11};
    chk_regs(exp, "R4 ordered fill");

    // R2 R10: read address and a foreign address are refused
    i2c_start;
    send_byte(8'hD3, 0);
    send_byte(8'h00, 0);
    send_byte(8'h00, 0);
    send_byte(8'h99, 0);
    i2c_stop;
    i2c_start;
    send_byte(8'hA4, 0);
    send_byte(8'h00, 0);
    send_byte(8'h55, 0);
    i2c_stop;
    chk_regs(exp, "R2 no change");

    // R4 R6: seven data bytes, the last is refused
    i2c_start;
    send_byte(8'hD2, 1);
    send_byte(8'hFF, 1);
    send_byte(8'h00, 1);
    for (int k = 0; k < 6; k++) send_byte(8'hA0 + 8'(k), 1);
    send_byte(8'hEE, 0);   // R6
    i2c_stop;
    exp = {8'hA5, 8'hA4, 8'hA3, 8'hA2, 8'hA1, 8'hA0};
    chk_regs(exp, "R6 overflow refused");

    // R5: partial byte at STOP is discarded
    i2c_start;
    send_byte(8'hD2, 1);
    send_byte(8'h00, 1);
    send_byte(8'h00, 1);
    send_byte(8'h77, 1);
    send_bits(8'h0F, 5);
    i2c_stop;
    exp[7:0] = 8'h77;
    chk_regs(exp, "R5 partial dropped");

    // R4 R5: repeated START restarts at register 0
    i2c_start;
    send_byte(8'hD2, 1);
    send_byte(8'h00, 1);
    send_byte(8'h00, 1);
    send_byte(8'h88, 1);
    send_bits(8'hF0, 3);
    scl_m = 1'b0;
    i2c_start;             // repeated START
    send_byte(8'hD2, 1);
    send_byte(8'h00, 1);
    send_byte(8'h00, 1);
    send_byte(8'h99, 1);
    i2c_stop;
    exp[7:0] = 8'h99;
    chk_regs(exp, "R4 restart at reg0");

    // R7: power-down releases pins and ignores the bus
    pd_n = 1'b0;
    wq(4);
    chk(pins_hiz && !sda_pull, "R7 pins released", 48'({pins_hiz, sda_pull}), 48'b10);
    i2c_start;
    send_byte(8'hD2, 0);
    send_byte(8'h00, 0);
    send_byte(8'h00, 0);
    send_byte(8'h12, 0);
    i2c_stop;
    chk_regs(exp, "R7 regs held");

    // R8: leaving power-down keeps registers, then writes work
    pd_n = 1'b1;
    wq(10);
    chk(!pins_hiz, "R8 pins back", 48'(pins_hiz), 48'd0);
    chk_regs(exp, "R8 regs kept");
    i2c_start;
    send_byte(8'hD2, 1);
    send_byte(8'h00, 1);
    send_byte(8'h00, 1);
    send_byte(8'h42, 1);
    i2c_stop;
    exp[7:0] = 8'h42;
    chk_regs(exp, "R8 write after wake");

    chk(ack_q.size() == 0, "R10 scoreboard drained", 48'(ack_q.size()), 48'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule